// File: doc/BRIEF.md
# Complement-Pattern Memory Self-Test Controller

This block is a self-test engine placed between a single-port synchronous RAM and its normal user. While the test-enable input is low, the user's address, write data and write strobe go straight to the RAM, and the RAM's read data goes straight back. When test-enable goes high, the engine takes over the RAM port. It then runs a fixed sequence of four phases. Each phase is one full write sweep followed by one full read sweep, so the whole test is eight sweeps and 8n memory operations.

The data word for an address is a pseudo-random function of that address and a seed. The engine can therefore recompute the expected value during a read sweep in either direction without storing anything. Phases alternate between that word and its bitwise complement. The first two phases sweep upward and the last two sweep downward. Each read result is compared one cycle after the read is issued. A mismatch sets a sticky fail flag and captures the first failing address. A done flag rises after the last comparison and stays high until test-enable is dropped.

The sequencer has five named states. IDLE waits for test-enable. WRITE issues one write per cycle and moves to READ after the last address. READ issues one read per cycle and moves to DRAIN after the last address. DRAIN compares the final read and then either moves to WRITE for the next phase or, after phase 4, to DONE. DONE holds. From every state, dropping test-enable returns to IDLE.

Top module: `cpat_mbist`

## Requirements
- R1: While test_en is low, mem_addr, mem_wdata and mem_we equal fn_addr, fn_wdata and fn_we. fn_rdata always equals mem_rdata.
- R2: test_en sampled high in IDLE clears fail and fail_addr. In the very next cycle the first write of phase 1 appears on the memory port at address 0.
- R3: Each phase drives 64 write cycles (mem_we=1), then 64 read cycles (mem_we=0), then one idle drain cycle (mem_we=0). Phases 1 and 2 step the address 0 to 63; phases 3 and 4 step it 63 down to 0.
- R4: The word for address a is P(a) = SEED ^ ((a * 32'h9E3779B1) mod 2^32), with SEED = 32'h5A3C96E1 by default. Phases 1 and 3 write P(a); phases 2 and 4 write ~P(a).
- R5: The RAM answers a read one cycle after it is issued. The last read of each phase is compared in the drain cycle. done rises 516 cycles after the start cycle, with fail already final.
- R6: fail rises on any read mismatch and stays high until the next start. It stays low for a fault-free memory.
- R7: fail_addr holds the address of the first mismatching read in test order and does not change on later mismatches.
- R8: done stays high while test_en stays high after completion. test_en low clears done and returns the block to pass-through.
- R9: Dropping test_en during a test aborts it at once (done low, pass-through restored). Raising test_en again restarts from phase 1 at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Self-test request; high hands the RAM port to the engine |
| fn_addr | input | 6 | User address |
| fn_wdata | input | 32 | User write data |
| fn_we | input | 1 | User write strobe |
| fn_rdata | output | 32 | Read data returned to the user |
| mem_addr | output | 6 | RAM address |
| mem_wdata | output | 32 | RAM write data |
| mem_we | output | 1 | RAM write strobe |
| mem_rdata | input | 32 | RAM read data, one cycle after the address |
| done | output | 1 | Test finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | 6 | First failing address |

## Verification
A fault-free RAM checks the exact operation stream, cycle by cycle, against the addresses, strobes and words the bench computes. This separates errors in sweep order, pattern or complement selection from errors in timing. Single stuck-at bits at random addresses and bit positions show that either polarity is caught, in the first or second phase depending on the pattern bit. Pairs of faults distinguish first-failure capture from last-failure capture. An aborted run followed by a clean rerun shows that the sequence restarts and that fail clears. Random user traffic with test_en low exercises the pass-through path.

// File: rtl/cpat_mbist_pkg.sv
package cpat_mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_READ  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } bist_state_e;

    localparam int unsigned PHASE_W    = 2;
    localparam int unsigned NUM_PHASES = 1 << PHASE_W;

endpackage

// File: rtl/cpat_addr_gen.sv
module cpat_addr_gen #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_down,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] ADDR_MAX = '1;
    localparam logic [AW-1:0] ADDR_MIN = '0;

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= ADDR_MIN;
        end else if (load) begin
            addr_q <= load_down ? ADDR_MAX : ADDR_MIN;
        end else if (step) begin
            addr_q <= down ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = down ? (addr_q == ADDR_MIN) : (addr_q == ADDR_MAX);

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !down && !last) |=> (addr_q == $past(addr_q) + 1'b1)); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && down && !last) |=> (addr_q == $past(addr_q) - 1'b1)); // R3

endmodule

// File: rtl/cpat_pattern.sv
module cpat_pattern #(
    parameter int unsigned    AW   = 6,
    parameter int unsigned    DW   = 32,
    parameter logic [DW-1:0]  SEED = 32'h5A3C_96E1,
    parameter logic [DW-1:0]  MIX  = 32'h9E37_79B1
) (
    input  logic [AW-1:0] addr,
    input  logic          invert,
    output logic [DW-1:0] word
);
    logic [DW-1:0] base;

    always_comb begin
        base = SEED ^ (DW'(addr) * MIX);
        word = invert ? ~base : base;
    end

endmodule

// File: rtl/cpat_resp.sv
module cpat_resp #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] exp_word,
    input  logic [DW-1:0] rdata,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    logic          pend_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          fail_q;
    logic [AW-1:0] faddr_q;
    logic          mism;

    // a read issued last cycle returns its data now
    assign mism = pend_q && (rdata != exp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
        end else begin
            pend_q <= issue;
            addr_q <= issue_addr;
            exp_q  <= exp_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q  <= 1'b0;
            faddr_q <= '0;
        end else if (clr) begin
            fail_q  <= 1'b0;
            faddr_q <= '0;
        end else if (mism && !fail_q) begin
            fail_q  <= 1'b1;
            faddr_q <= addr_q;
        end
    end

    assign fail      = fail_q;
    assign fail_addr = faddr_q;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clr) |=> fail_q); // R6
    AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fail_q); // R6
    AST_FADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clr) |=> $stable(faddr_q)); // R7

endmodule

// File: rtl/cpat_mbist.sv
module cpat_mbist
    import cpat_mbist_pkg::*;
#(
    parameter int unsigned    AW   = 6,
    parameter int unsigned    DW   = 32,
    parameter logic [DW-1:0]  SEED = 32'h5A3C_96E1,
    parameter logic [DW-1:0]  MIX  = 32'h9E37_79B1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic [AW-1:0] fn_addr,
    input  logic [DW-1:0] fn_wdata,
    input  logic          fn_we,
    output logic [DW-1:0] fn_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

    bist_state_e        state_q, state_d;
    logic [PHASE_W-1:0] phase_q, phase_d, phase_nxt;

    logic          ag_load, ag_load_down, ag_step, ag_last;
    logic [AW-1:0] ag_addr;
    logic [DW-1:0] pat_word;
    logic          bist_we, rd_issue, clr;

    assign phase_nxt = phase_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (test_en) begin
                    state_d = ST_WRITE;
                    phase_d = '0;
                end
            end
            ST_WRITE: if (ag_last) state_d = ST_READ;
            ST_READ:  if (ag_last) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (phase_q == LAST_PHASE) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_WRITE;
                    phase_d = phase_nxt;
                end
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
        if (!test_en) state_d = ST_IDLE;
    end

    // per-state actions
    always_comb begin
        ag_load      = 1'b0;
        ag_load_down = 1'b0;
        ag_step      = 1'b0;
        bist_we      = 1'b0;
        rd_issue     = 1'b0;
        clr          = 1'b0;
        if (test_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    ag_load = 1'b1;
                    clr     = 1'b1;
                end
                ST_WRITE: begin
                    bist_we = 1'b1;
                    if (ag_last) begin
                        ag_load      = 1'b1;
                        ag_load_down = phase_q[PHASE_W-1];
                    end else begin
                        ag_step = 1'b1;
                    end
                end
                ST_READ: begin
                    rd_issue = 1'b1;
                    ag_step  = !ag_last;
                end
                ST_DRAIN: begin
                    if (phase_q != LAST_PHASE) begin
                        ag_load      = 1'b1;
                        ag_load_down = phase_nxt[PHASE_W-1];
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    cpat_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_down (ag_load_down),
        .step      (ag_step),
        .down      (phase_q[PHASE_W-1]),
        .addr      (ag_addr),
        .last      (ag_last)
    );

    cpat_pattern #(.AW(AW), .DW(DW), .SEED(SEED), .MIX(MIX)) u_pat (
        .addr   (ag_addr),
        .invert (phase_q[0]),
        .word   (pat_word)
    );

    cpat_resp #(.AW(AW), .DW(DW)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .issue      (rd_issue),
        .issue_addr (ag_addr),
        .exp_word   (pat_word),
        .rdata      (mem_rdata),
        .fail       (fail),
        .fail_addr  (fail_addr)
    );

    assign mem_addr  = test_en ? ag_addr  : fn_addr;
    assign mem_wdata = test_en ? pat_word : fn_wdata;
    assign mem_we    = test_en ? bist_we  : fn_we;
    assign fn_rdata  = mem_rdata;
    assign done      = (state_q == ST_DONE);

    AST_WRITE_ONLY_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && state_q != ST_WRITE) |-> !mem_we); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_en) |=> done); // R8
    AST_ABORT_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !done); // R9
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && test_en) |=> (mem_addr == '0 && mem_we)); // R2

endmodule

// File: tb/tb_cpat_mbist.sv
`timescale 1ns/1ps

module tb_sram #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    input  logic          f0_en,
    input  logic [AW-1:0] f0_addr,
    input  logic [4:0]    f0_bit,
    input  logic          f0_val,
    input  logic          f1_en,
    input  logic [AW-1:0] f1_addr,
    input  logic [4:0]    f1_bit,
    input  logic          f1_val
);
    logic [DW-1:0] mem [1<<AW];
    logic [DW-1:0] rv;

    always_comb begin
        rv = mem[addr];
        if (f0_en && addr == f0_addr) rv[f0_bit] = f0_val;
        if (f1_en && addr == f1_addr) rv[f1_bit] = f1_val;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= rv;
    end
endmodule

module tb_cpat_mbist;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = 32;
    localparam logic [DW-1:0] SEED = 32'h5A3C_96E1;
    localparam logic [DW-1:0] MIX  = 32'h9E37_79B1;
    localparam int unsigned N = 1 << AW;
    localparam int unsigned PHASE_LEN = 2 * N + 1;
    localparam int unsigned RUN_LEN = 4 * PHASE_LEN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic [AW-1:0] fn_addr = '0;
    logic [DW-1:0] fn_wdata = '0;
    logic          fn_we = 1'b0;
    logic [DW-1:0] fn_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          done, fail;
    logic [AW-1:0] fail_addr;

    logic          f0_en = 1'b0, f1_en = 1'b0;
    logic [AW-1:0] f0_addr = '0, f1_addr = '0;
    logic [4:0]    f0_bit = '0, f1_bit = '0;
    logic          f0_val = 1'b0, f1_val = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cpat_mbist #(.AW(AW), .DW(DW), .SEED(SEED), .MIX(MIX)) dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en),
        .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_we(fn_we), .fn_rdata(fn_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    tb_sram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .addr(mem_addr), .wdata(mem_wdata), .we(mem_we), .rdata(mem_rdata),
        .f0_en(f0_en), .f0_addr(f0_addr), .f0_bit(f0_bit), .f0_val(f0_val),
        .f1_en(f1_en), .f1_addr(f1_addr), .f1_bit(f1_bit), .f1_val(f1_val)
    );

    function automatic logic [DW-1:0] pat(input int unsigned a, input bit inv);
        logic [DW-1:0] b;
        b = SEED ^ (DW'(a) * MIX);
        return inv ? ~b : b;
    endfunction

    // phase index (0 or 1) that first exposes a stuck bit
    function automatic int det_phase(input int unsigned a, input int unsigned b, input bit v);
        logic [DW-1:0] w;
        w = pat(a, 1'b0);
        return (w[b] != v) ? 0 : 1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // starts a test at a negedge and follows it to completion
    task automatic run_full(input string tag);
        int e_seq, e_dat, e_done;
        e_seq = 0; e_dat = 0; e_done = 0;
        test_en = 1'b1;
        for (int k = 0; k < int'(RUN_LEN); k++) begin
            int ph, j, idx, ea;
            @(negedge clk);
            ph = k / int'(PHASE_LEN);
            j  = k % int'(PHASE_LEN);
            idx = (j < int'(N)) ? j : j - int'(N);
            ea = (ph >= 2) ? int'(N) - 1 - idx : idx;
            if (done) e_done++;
            if (j < int'(N)) begin
                if (!mem_we || mem_addr != AW'(ea)) e_seq++;
                if (mem_wdata != pat(ea, ph[0])) e_dat++;
            end else if (j < 2 * int'(N)) begin
                if (mem_we || mem_addr != AW'(ea)) e_seq++;
            end else begin
                if (mem_we) e_seq++;
            end
        end
        chk(e_seq == 0, "R3", {tag, " sweep order/strobe errors"}, e_seq, 0);
        chk(e_dat == 0, "R4", {tag, " write data errors"}, e_dat, 0);
        chk(e_done == 0, "R5", {tag, " done early"}, e_done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R5", {tag, " done after 516 cycles"}, done, 1);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd13579);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R2", "reset done", done, 0);
        chk(fail == 1'b0, "R6", "reset fail", fail, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: pass-through with random user traffic
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom);
            d = $urandom;
            fn_addr = a; fn_wdata = d; fn_we = 1'b1;
            #1;
            chk(mem_addr == a && mem_wdata == d && mem_we == 1'b1, "R1", "write passthrough",
                {mem_addr, mem_wdata}, {a, d});
            @(negedge clk);
            fn_we = 1'b0; fn_wdata = $urandom;
            @(negedge clk);
            chk(fn_rdata == d, "R1", "user readback", fn_rdata, d);
        end

        // R2/R3/R4/R5/R6: fault-free run
        run_full("clean");
        chk(fail == 1'b0, "R6", "clean run fail", fail, 0);
        // R8: done held while test_en high
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R8", "done held", done, 1);
        test_en = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R8", "done cleared", done, 0);
        fn_addr = 6'd17; fn_we = 1'b0; #1;
        chk(mem_addr == 6'd17 && mem_we == 1'b0, "R8", "passthrough after done", mem_addr, 17);

        // R6/R7: single stuck-at faults at random places
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            f0_en = 1'b1; f0_addr = AW'($urandom); f0_bit = 5'($urandom); f0_val = 1'($urandom);
            if (i == 0) f0_addr = '1;
            if (i == 1) f0_addr = '0;
            run_full("single fault");
            chk(fail == 1'b1, "R6", "single fault detected", fail, 1);
            chk(fail_addr == f0_addr, "R7", "single fault address", fail_addr, f0_addr);
            test_en = 1'b0;
            @(negedge clk);
            chk(fail == 1'b1, "R6", "fail sticky after test_en low", fail, 1);
        end

        // R7: two faults, first in test order captured
        for (int i = 0; i < 4; i++) begin
            int p0, p1, ea;
            @(negedge clk);
            f0_en = 1'b1; f0_addr = AW'($urandom); f0_bit = 5'($urandom); f0_val = 1'($urandom);
            f1_en = 1'b1; f1_bit = 5'($urandom); f1_val = 1'($urandom);
            f1_addr = f0_addr + AW'(1 + ($urandom % (N - 1)));
            p0 = det_phase(f0_addr, f0_bit, f0_val);
            p1 = det_phase(f1_addr, f1_bit, f1_val);
            if (p0 < p1) ea = f0_addr;
            else if (p1 < p0) ea = f1_addr;
            else ea = (f0_addr < f1_addr) ? f0_addr : f1_addr;
            run_full("double fault");
            chk(fail_addr == AW'(ea), "R7", "first failing address", fail_addr, ea);
            test_en = 1'b0;
        end
        f0_en = 1'b0; f1_en = 1'b0;

        // R9: abort mid-test, then restart clean; R6 start clears old fail
        @(negedge clk);
        test_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(fail == 1'b0, "R6", "start clears fail", fail, 0);
        repeat (200) @(negedge clk);
        test_en = 1'b0;
        fn_addr = 6'd5; fn_wdata = 32'hCAFE_F00D; fn_we = 1'b0;
        #1;
        chk(mem_addr == 6'd5 && mem_wdata == 32'hCAFE_F00D && mem_we == 1'b0, "R9",
            "abort restores passthrough", mem_addr, 5);
        @(negedge clk);
        chk(done == 1'b0, "R9", "abort done low", done, 0);
        run_full("restart");
        chk(fail == 1'b0, "R9", "restart clean fail", fail, 0);
        test_en = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule